// File: doc/BRIEF.md
# Sixteen-bit timer with byte-wide atomic register access

This block is a 16-bit up-counter paired with two 16-bit compare registers, all reached from an 8-bit bus one byte at a time. The bus sees three 16-bit registers: the counter, compare A and compare B. Each has a low-byte and a high-byte address. There is also a match-flag register. One 8-bit temporary byte is shared by all three 16-bit registers, so software can move a full 16-bit value in two byte accesses without tearing.

For a write, software puts the high byte into the temporary byte first. The low-byte write then commits both halves in one cycle. For a read, software reads the low byte first, which captures the live high byte into the temporary byte. The following high-byte read returns that captured byte.

The counter steps once for each cycle in which the count-enable strobe from an external clock selector is high. Each compare unit latches a sticky match flag when the counter equals its compare value on a count step. A software write to the counter suppresses matches for both units on the next count step. This stops a freshly loaded value from producing a match that software caused itself.

Top module: `tmr16_atomic`

## Requirements
- R1: After reset the counter, both compare registers, the temporary byte and both match flags read as zero.
- R2: A write to a high-byte address (1 = counter, 3 = compare A, 5 = compare B) loads only the temporary byte. The addressed 16-bit register keeps its value.
- R3: A write to a low-byte address (0 = counter, 2 = compare A, 4 = compare B) loads the addressed register with {temporary byte, write data}, visible in the next cycle.
- R4: rdata_o is combinational from addr_i. A low-byte address returns the live low byte. A read strobe on a low-byte address also copies the live high byte into the temporary byte. Any high-byte address returns the temporary byte.
- R5: The temporary byte is shared by all three registers. Any intervening high-byte write or low-byte read of another register replaces the byte that a pending access to a different register relies on.
- R6: Each cycle with tick_i high advances the counter by one, wrapping from 0xFFFF to 0x0000. Without tick_i the counter holds.
- R7: A counter low-byte write in the same cycle as tick_i loads the written value, and that count step is discarded.
- R8: On a count step that is not blocked, if the counter value before the step equals a compare register, that unit's flag is set in the next cycle. The flag then stays set until it is cleared.
- R9: A counter low-byte write blocks the compare of both units on the next count step only, however many idle cycles come between. Later steps compare normally.
- R10: Address 6 reads {6'b0, flag B, flag A}. Writing a one to bit 0 or bit 1 clears the corresponding flag, and writing a zero has no effect. A flag being set wins over a clear in the same cycle. match_a_o and match_b_o show the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 3 | Byte register address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe (side effect on low-byte reads) |
| tick_i | input | 1 | Count enable from clock selector |
| rdata_o | output | 8 | Read data for addr_i |
| match_a_o | output | 1 | Sticky match flag of compare A |
| match_b_o | output | 1 | Sticky match flag of compare B |

## Verification
The hardest case to reach is a compare match that the design must swallow. The counter has to be loaded with exactly the value held by both compare registers, and then the very next count step must be allowed to pass without raising a flag. The bench sets both compare values, loads the counter with that same value, and shows that one step leaves the flags clear. It then reloads one below the match, lets the blocked step and the following step pass, and shows that the next match is raised normally. A further case holds the block across idle cycles, and another puts a flag clear and a match on the same edge.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam int BYTE_W  = 8;
  localparam int DATA_W  = 2 * BYTE_W;
  localparam int ADDR_W  = 3;
  localparam int NUM_CMP = 2;
  localparam int NUM_REG = NUM_CMP + 1;

  localparam logic [ADDR_W-1:0] AD_CNT_LO  = 3'd0;
  localparam logic [ADDR_W-1:0] AD_CNT_HI  = 3'd1;
  localparam logic [ADDR_W-1:0] AD_CMPA_LO = 3'd2;
  localparam logic [ADDR_W-1:0] AD_CMPB_LO = 3'd4;
  localparam logic [ADDR_W-1:0] AD_FLAGS   = 3'd6;
endpackage

// File: rtl/tmr16_bus.sv
module tmr16_bus
  import tmr16_pkg::*;
(
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [BYTE_W-1:0]                wdata_i,
  input  logic                             wr_i,
  input  logic                             rd_i,
  input  logic [DATA_W-1:0]                cnt_i,
  input  logic [NUM_CMP-1:0][DATA_W-1:0]   cmp_i,
  input  logic [NUM_CMP-1:0]               flag_i,
  output logic [BYTE_W-1:0]                temp_o,
  output logic                             cnt_wr_o,
  output logic [NUM_CMP-1:0]               cmp_wr_o,
  output logic [DATA_W-1:0]                wval_o,
  output logic [NUM_CMP-1:0]               flag_clr_o,
  output logic [BYTE_W-1:0]                rdata_o
);
  localparam int IDX_W = ADDR_W - 1;

  logic [BYTE_W-1:0]              temp_q;
  logic [NUM_REG-1:0][DATA_W-1:0] live;
  logic [IDX_W-1:0]               idx;
  logic                           is_hi, is_wide, is_flags;
  logic [NUM_REG-1:0]             lo_wr;

  assign idx      = addr_i[ADDR_W-1:1];
  assign is_hi    = addr_i[0];
  assign is_wide  = (32'(idx) < NUM_REG);
  assign is_flags = (addr_i == AD_FLAGS);

  always_comb begin
    live[0] = cnt_i;
    for (int i = 0; i < NUM_CMP; i++) live[i+1] = cmp_i[i];
  end

  // shared high-byte staging
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) temp_q <= '0;
    else if (wr_i && is_wide && is_hi) temp_q <= wdata_i;
    else if (rd_i && !wr_i && is_wide && !is_hi) temp_q <= live[idx][DATA_W-1:BYTE_W];
  end

  always_comb begin
    for (int i = 0; i < NUM_REG; i++)
      lo_wr[i] = wr_i && !is_hi && (32'(idx) == i);
  end

  assign cnt_wr_o   = lo_wr[0];
  assign cmp_wr_o   = lo_wr[NUM_REG-1:1];
  assign wval_o     = {temp_q, wdata_i};
  assign flag_clr_o = (wr_i && is_flags) ? wdata_i[NUM_CMP-1:0] : '0;
  assign temp_o     = temp_q;

  always_comb begin
    rdata_o = '0;
    if (is_wide) rdata_o = is_hi ? temp_q : live[idx][BYTE_W-1:0];
    else if (is_flags) rdata_o = BYTE_W'(flag_i);
  end
endmodule

// File: rtl/tmr16_counter.sv
module tmr16_counter
  import tmr16_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_val_i,
  input  logic              tick_i,
  output logic [DATA_W-1:0] cnt_o,
  output logic              blk_o,
  output logic              cmp_en_o
);
  logic [DATA_W-1:0] cnt_q;
  logic              blk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      blk_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
      blk_q <= 1'b1;
    end else if (tick_i) begin
      cnt_q <= cnt_q + 1'b1;
      blk_q <= 1'b0;
    end
  end

  assign cmp_en_o = tick_i && !load_i && !blk_q;
  assign cnt_o    = cnt_q;
  assign blk_o    = blk_q;
endmodule

// File: rtl/tmr16_cmp.sv
module tmr16_cmp
  import tmr16_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_val_i,
  input  logic              cmp_en_i,
  input  logic [DATA_W-1:0] cnt_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] cmp_o,
  output logic              flag_o
);
  logic [DATA_W-1:0] cmp_q;
  logic              flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cmp_q <= '0;
    else if (load_i) cmp_q <= load_val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else if (cmp_en_i && (cnt_i == cmp_q)) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign cmp_o  = cmp_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/tmr16_atomic.sv
module tmr16_atomic
  import tmr16_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              tick_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              match_a_o,
  output logic              match_b_o
);
  logic [DATA_W-1:0]              cnt_w;
  logic [NUM_CMP-1:0][DATA_W-1:0] cmp_w;
  logic [NUM_CMP-1:0]             flag_w, cmp_wr_w, flag_clr_w;
  logic [BYTE_W-1:0]              temp_w;
  logic [DATA_W-1:0]              wval_w;
  logic                           cnt_wr_w, blk_w, cmp_en_w;

  tmr16_bus u_bus (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .wr_i, .rd_i,
    .cnt_i      (cnt_w),
    .cmp_i      (cmp_w),
    .flag_i     (flag_w),
    .temp_o     (temp_w),
    .cnt_wr_o   (cnt_wr_w),
    .cmp_wr_o   (cmp_wr_w),
    .wval_o     (wval_w),
    .flag_clr_o (flag_clr_w),
    .rdata_o
  );

  tmr16_counter u_cnt (
    .clk_i, .rst_ni,
    .load_i     (cnt_wr_w),
    .load_val_i (wval_w),
    .tick_i,
    .cnt_o      (cnt_w),
    .blk_o      (blk_w),
    .cmp_en_o   (cmp_en_w)
  );

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    tmr16_cmp u_cmp (
      .clk_i, .rst_ni,
      .load_i     (cmp_wr_w[g]),
      .load_val_i (wval_w),
      .cmp_en_i   (cmp_en_w),
      .cnt_i      (cnt_w),
      .clr_i      (flag_clr_w[g]),
      .cmp_o      (cmp_w[g]),
      .flag_o     (flag_w[g])
    );
  end

  assign match_a_o = flag_w[0];
  assign match_b_o = flag_w[1];
endmodule

// File: rtl/tmr16_atomic_chk.sv
module tmr16_atomic_chk
  import tmr16_pkg::*;
(
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic [ADDR_W-1:0]              addr_i,
  input logic [BYTE_W-1:0]              wdata_i,
  input logic                           wr_i,
  input logic                           rd_i,
  input logic                           tick_i,
  input logic [BYTE_W-1:0]              rdata_o,
  input logic [DATA_W-1:0]              cnt,
  input logic [NUM_CMP-1:0][DATA_W-1:0] cmp,
  input logic [BYTE_W-1:0]              temp,
  input logic                           blk,
  input logic [NUM_CMP-1:0]             flag
);
  logic cnt_lo_wr;
  assign cnt_lo_wr = wr_i && (addr_i == AD_CNT_LO);

  a_r3_cnt_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_lo_wr |=> cnt == {$past(temp), $past(wdata_i)});

  a_r2_hi_no_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == AD_CNT_HI && !tick_i) |=> $stable(cnt));

  a_r4_hi_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == AD_CNT_HI) |-> rdata_o == temp);

  a_r6_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !cnt_lo_wr) |=> cnt == DATA_W'($past(cnt) + 1'b1));

  a_r6_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !cnt_lo_wr && cnt == '1) |=> cnt == '0);

  a_r9_block_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && blk && !flag[0]) |=> !flag[0]);

  a_r9_block_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && blk && !flag[1]) |=> !flag[1]);

  a_r8_cause_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag[0]) |-> ($past(tick_i) && $past(cnt == cmp[0])));

  a_r8_sticky_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag[0] && !(wr_i && addr_i == AD_FLAGS && wdata_i[0])) |=> flag[0]);

  a_r8_sticky_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag[1] && !(wr_i && addr_i == AD_FLAGS && wdata_i[1])) |=> flag[1]);
endmodule

bind tmr16_atomic tmr16_atomic_chk u_chk (
  .clk_i, .rst_ni, .addr_i, .wdata_i, .wr_i, .rd_i, .tick_i, .rdata_o,
  .cnt  (cnt_w),
  .cmp  (cmp_w),
  .temp (temp_w),
  .blk  (blk_w),
  .flag (flag_w)
);

// File: tb/tb_tmr16_atomic.sv
module tb_tmr16_atomic;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic       wr_i = 1'b0, rd_i = 1'b0, tick_i = 1'b0;
  logic [7:0] rdata_o;
  logic       match_a_o, match_b_o;
  int         n_chk = 0, n_err = 0;
  logic       done = 1'b0;

  always #5 clk_i = ~clk_i;

  tmr16_atomic dut (.*);

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bwr(input logic [2:0] a, input logic [7:0] d);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(posedge clk_i); #1;
    wr_i = 1'b0;
  endtask

  task automatic brd(input logic [2:0] a, output logic [7:0] d);
    addr_i = a; rd_i = 1'b1;
    #1 d = rdata_o;
    @(posedge clk_i); #1;
    rd_i = 1'b0;
  endtask

  task automatic wr16(input logic [2:0] lo, input logic [15:0] v);
    bwr(lo + 3'd1, v[15:8]);
    bwr(lo, v[7:0]);
  endtask

  task automatic rd16(input logic [2:0] lo, output logic [15:0] v);
    logic [7:0] l, h;
    brd(lo, l);
    brd(lo + 3'd1, h);
    v = {h, l};
  endtask

  task automatic ticks(input int n);
    tick_i = 1'b1;
    repeat (n) @(posedge clk_i);
    #1 tick_i = 1'b0;
  endtask

  task automatic rd_flags(input string req, input logic [1:0] exp);
    logic [7:0] f;
    brd(3'd6, f);
    chk(req, f, {6'b0, exp});
    chk({req, " ports"}, {match_b_o, match_a_o}, exp);
  endtask

  task automatic t_reset();
    logic [7:0] b;
    logic [15:0] v;
    brd(3'd1, b); chk("R1 temp", b, 0);
    rd16(3'd0, v); chk("R1 cnt", v, 0);
    rd16(3'd2, v); chk("R1 cmpa", v, 0);
    rd16(3'd4, v); chk("R1 cmpb", v, 0);
    rd_flags("R1 flags", 2'b00);
  endtask

  task automatic t_atomic();
    logic [15:0] v;
    logic [7:0] b;
    wr16(3'd0, 16'h1234);
    rd16(3'd0, v); chk("R3 cnt commit", v, 16'h1234);
    bwr(3'd3, 8'hAB);
    brd(3'd2, b); chk("R2 cmpa lo untouched", b, 0);
    brd(3'd3, b); chk("R2 cmpa hi untouched", b, 0);
    bwr(3'd5, 8'h5A);
    brd(3'd4, b);
    brd(3'd5, b); chk("R2 cmpb hi untouched", b, 0);
  endtask

  task automatic t_shared();
    logic [15:0] v;
    logic [7:0] b;
    bwr(3'd3, 8'h56);
    bwr(3'd1, 8'h77);
    bwr(3'd2, 8'h9A);
    rd16(3'd2, v); chk("R5 write corrupted", v, 16'h779A);
    brd(3'd0, b); chk("R4 lo live", b, 8'h34);
    brd(3'd2, b);
    brd(3'd1, b); chk("R5 read corrupted", b, 8'h77);
    brd(3'd0, b);
    brd(3'd1, b); chk("R4 hi returns capture", b, 8'h12);
  endtask

  task automatic t_count();
    logic [15:0] v;
    ticks(3);
    rd16(3'd0, v); chk("R6 step", v, 16'h1237);
    repeat (4) @(posedge clk_i);
    #1 rd16(3'd0, v); chk("R6 hold", v, 16'h1237);
    wr16(3'd0, 16'hFFFE);
    ticks(2);
    rd16(3'd0, v); chk("R6 wrap", v, 16'h0000);
  endtask

  task automatic t_prio();
    logic [15:0] v;
    bwr(3'd1, 8'h40);
    addr_i = 3'd0; wdata_i = 8'h00; wr_i = 1'b1; tick_i = 1'b1;
    @(posedge clk_i); #1;
    wr_i = 1'b0; tick_i = 1'b0;
    rd16(3'd0, v); chk("R7 write beats tick", v, 16'h4000);
  endtask

  task automatic t_match();
    bwr(3'd6, 8'h03);
    wr16(3'd2, 16'h0010);
    wr16(3'd4, 16'h0012);
    wr16(3'd0, 16'h000E);
    ticks(3);
    rd_flags("R8 match A", 2'b01);
    ticks(2);
    rd_flags("R8 match B", 2'b11);
    ticks(3);
    rd_flags("R8 sticky", 2'b11);
    bwr(3'd6, 8'h01);
    rd_flags("R10 clear A", 2'b10);
    bwr(3'd6, 8'h00);
    rd_flags("R10 zero no effect", 2'b10);
    bwr(3'd6, 8'h02);
    rd_flags("R10 clear B", 2'b00);
  endtask

  task automatic t_block();
    logic [15:0] v;
    wr16(3'd2, 16'h0020);
    wr16(3'd4, 16'h0020);
    wr16(3'd0, 16'h0020);
    ticks(1);
    rd_flags("R9 match blocked", 2'b00);
    rd16(3'd0, v); chk("R9 blocked step counts", v, 16'h0021);
    wr16(3'd0, 16'h001F);
    ticks(2);
    rd_flags("R9 later step matches", 2'b11);
    bwr(3'd6, 8'h03);
    wr16(3'd0, 16'h0020);
    repeat (3) @(posedge clk_i);
    #1 ticks(1);
    rd_flags("R9 block survives idle", 2'b00);
  endtask

  task automatic t_set_wins();
    wr16(3'd0, 16'h001F);
    ticks(1);
    rd_flags("R10 pre", 2'b00);
    addr_i = 3'd6; wdata_i = 8'h03; wr_i = 1'b1; tick_i = 1'b1;
    @(posedge clk_i); #1;
    wr_i = 1'b0; tick_i = 1'b0;
    rd_flags("R10 set beats clear", 2'b11);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(posedge clk_i); #1;
    t_reset();
    t_atomic();
    t_shared();
    t_count();
    t_prio();
    t_match();
    t_block();
    t_set_wins();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule